// File: doc/BRIEF.md
# Stacked Flash Region Chip-Select Decoder

This block sits in front of a serial flash controller's memory-mapped read path. Up to four flash devices share one linear address window. They are placed end to end in a fixed order: slot A1 at the bottom, then A2, then B1, then B2. Each device's footprint comes from a programmable size held in kilobytes. A slot's lower boundary is therefore not a stored base address. It is the sum of the sizes of all slots below it. A slot programmed to zero takes no space, and the next slot starts where the last non-empty one ended.

For every valid read address the block returns, one clock later, a one-hot chip select naming the device that owns the address and the byte offset inside that device. If the address lies past the top of the last populated device, it returns a miss flag instead. The usual setup gives one slot the whole window and leaves the other three at zero. The block also supports any mix of sizes, so that several devices can be placed back to back.

Top module: `stkdec_top`

## Requirements
- R1: After reset all four sizes are zero and the outputs are idle (rsp_valid, rsp_cs and rsp_miss low, rsp_offset zero), so the first request after reset misses.
- R2: The slots are stacked in ascending address order with slot code 0 = A1, 1 = A2, 2 = B1, 3 = B2 on cfg_slot. Bit i of rsp_cs selects the slot with code i.
- R3: A size value of N covers N*1024 bytes, so a slot spans [start, start + N*1024).
- R4: A slot whose size is zero occupies no addresses and is never selected. The next slot begins at the same start address.
- R5: When one slot holds the full window size and the others are zero, every address inside the window selects that slot with an offset equal to the address.
- R6: rsp_offset equals the request address minus the start of the selected slot.
- R7: An address at or above the sum of all four sizes raises rsp_miss, leaves rsp_cs zero and returns rsp_offset zero.
- R8: A request sampled on one rising edge is answered on the next edge. rsp_valid follows req_valid with exactly one cycle of delay. While rsp_valid is low, rsp_cs, rsp_miss and rsp_offset are zero.
- R9: A size written on one edge governs requests sampled from the next edge onward. A request sampled on the same edge as the write is decoded with the old sizes.
- R10: rsp_cs never has more than one bit set, and a valid response carries either exactly one chip select or the miss flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Size write strobe |
| cfg_slot | input | 2 | Slot written (0 A1, 1 A2, 2 B1, 3 B2) |
| cfg_kb | input | SIZE_W | New size in kilobytes |
| req_valid | input | 1 | Read address valid |
| req_addr | input | ADDR_W | Linear read address |
| rsp_valid | output | 1 | Decode result valid |
| rsp_cs | output | 4 | One-hot chip select, bit i = slot code i |
| rsp_offset | output | ADDR_W | Byte offset inside the selected device |
| rsp_miss | output | 1 | Address beyond all populated devices |

## Verification
A size write and a decode can land on the same clock edge. The bench provokes this by driving cfg_we together with req_valid, aimed at an address that sits above the old top of the window but inside the new one. The scoreboard expects a miss for that request, because it is decoded with the sizes as they were before the write. The identical address, sent on the following cycle, must then hit the newly enlarged slot layout with the shifted offset.

// File: rtl/stkdec_pkg.sv
// Package: shared constants and slot encoding for the stacked region decoder.
// Assumes exactly four slots; the slot code order is the address stacking order.
package stkdec_pkg;
    localparam int NUM_SLOTS = 4;
    localparam int SLOT_W    = 2;
    localparam int KB_SHIFT  = 10;

    typedef enum logic [SLOT_W-1:0] {
        SLOT_A1 = 2'd0,
        SLOT_A2 = 2'd1,
        SLOT_B1 = 2'd2,
        SLOT_B2 = 2'd3
    } slot_e;
endpackage

// File: rtl/stkdec_size_bank.sv
// Module: holds the four per-slot sizes in kilobytes.
// Assumes one write per cycle; a write lands on the clock edge it is sampled at.
module stkdec_size_bank
    import stkdec_pkg::*;
#(
    parameter int SIZE_W = 22
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [SLOT_W-1:0]                wr_slot,
    input  logic [SIZE_W-1:0]                wr_kb,
    output logic [NUM_SLOTS-1:0][SIZE_W-1:0] sizes_o
);

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        // Per-slot size register: cleared on reset, loaded when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sizes_o[s] <= '0;
            end else if (wr_en && (wr_slot == SLOT_W'(s))) begin
                sizes_o[s] <= wr_kb;
            end
        end
    end

endmodule

// File: rtl/stkdec_bound_chain.sv
// Module: turns per-slot kilobyte sizes into byte start/end bounds by running sum.
// Assumes BOUND_W is wide enough for the total of all sizes in bytes.
module stkdec_bound_chain
    import stkdec_pkg::*;
#(
    parameter int SIZE_W  = 22,
    parameter int BOUND_W = 34
) (
    input  logic [NUM_SLOTS-1:0][SIZE_W-1:0]  sizes_i,
    output logic [NUM_SLOTS-1:0][BOUND_W-1:0] starts_o,
    output logic [NUM_SLOTS-1:0][BOUND_W-1:0] ends_o
);

    logic [NUM_SLOTS-1:0][BOUND_W-1:0] span_bytes;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_link
        // Byte span of this slot.
        assign span_bytes[s] = BOUND_W'(sizes_i[s]) << KB_SHIFT;

        if (s == 0) begin : g_base
            // The lowest slot starts at address zero.
            assign starts_o[s] = '0;
        end else begin : g_stack
            // Every other slot starts where the one below ends.
            assign starts_o[s] = ends_o[s-1];
        end

        // Upper bound, exclusive.
        assign ends_o[s] = starts_o[s] + span_bytes[s];
    end

endmodule

// File: rtl/stkdec_slot_match.sv
// Module: range test and offset for one slot.
// Assumes start <= end; an empty range (start == end) never matches.
module stkdec_slot_match #(
    parameter int ADDR_W  = 32,
    parameter int BOUND_W = 34
) (
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [BOUND_W-1:0] start_i,
    input  logic [BOUND_W-1:0] end_i,
    output logic               hit_o,
    output logic [ADDR_W-1:0]  offset_o
);

    logic [BOUND_W-1:0] addr_ext;
    logic [BOUND_W-1:0] diff;

    assign addr_ext = BOUND_W'(addr_i);

    // Half-open range compare and distance from the slot base.
    always_comb begin
        hit_o    = (addr_ext >= start_i) && (addr_ext < end_i);
        diff     = addr_ext - start_i;
        offset_o = diff[ADDR_W-1:0];
    end

endmodule

// File: rtl/stkdec_top.sv
// Module: stacked flash region chip-select decoder, top level.
// Maps a linear read address onto one of four end-to-end devices and
// registers chip select, offset and miss with one cycle of latency.
// Assumes requests and size writes are synchronous to clk.
module stkdec_top
    import stkdec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 22
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_slot,
    input  logic [SIZE_W-1:0]    cfg_kb,
    input  logic                 req_valid,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 rsp_valid,
    output logic [3:0]           rsp_cs,
    output logic [ADDR_W-1:0]    rsp_offset,
    output logic                 rsp_miss
);

    localparam int BOUND_W = SIZE_W + KB_SHIFT + 2;

    logic [NUM_SLOTS-1:0][SIZE_W-1:0]  size_q;
    logic [NUM_SLOTS-1:0][BOUND_W-1:0] slot_start;
    logic [NUM_SLOTS-1:0][BOUND_W-1:0] slot_end;
    logic [NUM_SLOTS-1:0]              slot_hit;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0]  slot_off;
    logic [ADDR_W-1:0]                 off_sel;

    stkdec_size_bank #(.SIZE_W(SIZE_W)) u_sizes (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we),
        .wr_slot (cfg_slot),
        .wr_kb   (cfg_kb),
        .sizes_o (size_q)
    );

    stkdec_bound_chain #(.SIZE_W(SIZE_W), .BOUND_W(BOUND_W)) u_bounds (
        .sizes_i  (size_q),
        .starts_o (slot_start),
        .ends_o   (slot_end)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_match
        stkdec_slot_match #(.ADDR_W(ADDR_W), .BOUND_W(BOUND_W)) u_match (
            .addr_i   (req_addr),
            .start_i  (slot_start[s]),
            .end_i    (slot_end[s]),
            .hit_o    (slot_hit[s]),
            .offset_o (slot_off[s])
        );
    end

    // Pick the offset of the slot that matched (ranges are disjoint).
    always_comb begin
        off_sel = '0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (slot_hit[s]) off_sel = off_sel | slot_off[s];
        end
    end

    // Output stage: one-cycle registered decode, zeros when no request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_cs     <= '0;
            rsp_offset <= '0;
            rsp_miss   <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_cs     <= slot_hit;
                rsp_offset <= off_sel;
                rsp_miss   <= ~|slot_hit;
            end else begin
                rsp_cs     <= '0;
                rsp_offset <= '0;
                rsp_miss   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/stkdec_checker.sv
// Module: temporal checks on the decoder's ports and size registers.
// Assumes synchronous active-low reset; bound into stkdec_top below.
module stkdec_checker
    import stkdec_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 22
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             req_valid,
    input logic [ADDR_W-1:0]                req_addr,
    input logic                             rsp_valid,
    input logic [3:0]                       rsp_cs,
    input logic [ADDR_W-1:0]                rsp_offset,
    input logic                             rsp_miss,
    input logic [NUM_SLOTS-1:0][SIZE_W-1:0] sizes
);

    // R8: a request is answered on the next edge
    a_r8_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // R8: no response without a request
    a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    // R8: idle outputs stay zero
    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_cs == '0) && !rsp_miss && (rsp_offset == '0));

    // R10: at most one chip select
    a_r10_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_cs));

    // R10: valid response is either a hit or a miss, never both or neither
    a_r10_hit_xor_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_miss != (rsp_cs != '0)));

    // R7: a miss carries no chip select and a zero offset
    a_r7_miss_clean: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_miss |-> (rsp_cs == '0) && (rsp_offset == '0));

    // R6: the offset never exceeds the request address
    a_r6_offset_bound: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_offset <= $past(req_addr)));

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot_chk
        // R3: offset lies inside the selected slot's byte span
        a_r3_offset_in_span: assert property (@(posedge clk) disable iff (!rst_n)
            rsp_cs[s] |-> (64'(rsp_offset) < (64'($past(sizes[s])) << KB_SHIFT)));
    end

endmodule

bind stkdec_top stkdec_checker #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_cs     (rsp_cs),
    .rsp_offset (rsp_offset),
    .rsp_miss   (rsp_miss),
    .sizes      (size_q)
);

// File: tb/tb_stkdec_top.sv
// Scoreboard bench: a driver pushes expected decodes, a monitor pops and compares.
module tb_stkdec_top;

    localparam int ADDR_W = 32;
    localparam int SIZE_W = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_we = 1'b0;
    logic [1:0]        cfg_slot = '0;
    logic [SIZE_W-1:0] cfg_kb = '0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              rsp_valid;
    logic [3:0]        rsp_cs;
    logic [ADDR_W-1:0] rsp_offset;
    logic              rsp_miss;

    stkdec_top #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_slot(cfg_slot),
        .cfg_kb(cfg_kb), .req_valid(req_valid), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_cs(rsp_cs), .rsp_offset(rsp_offset),
        .rsp_miss(rsp_miss)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [3:0]        cs;
        logic [ADDR_W-1:0] off;
        logic              miss;
        int                cyc;
        string             tag;
    } exp_t;

    exp_t        sb[$];
    int unsigned msize [4];
    int          n_checks = 0;
    int          n_fail = 0;
    int          cyc_cnt = 0;
    bit          done = 1'b0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    // Reference decode from the requirements (R2, R3, R4, R6, R7).
    function automatic void model(input logic [ADDR_W-1:0] a, output exp_t e);
        longint st = 0;
        longint en;
        e.cs = '0; e.off = '0; e.miss = 1'b1;
        for (int i = 0; i < 4; i++) begin
            en = st + (longint'(msize[i]) << 10);
            if (longint'(a) >= st && longint'(a) < en) begin
                e.cs[i] = 1'b1;
                e.off   = ADDR_W'(longint'(a) - st);
                e.miss  = 1'b0;
            end
            st = en;
        end
    endfunction

    // Driver: one cycle of stimulus; model is updated after the push (R9).
    task automatic cycle(input bit we, input int slot, input int unsigned kb,
                         input bit rv, input logic [ADDR_W-1:0] a, input string tag);
        exp_t e;
        @(negedge clk);
        cfg_we    = we;
        cfg_slot  = 2'(slot);
        cfg_kb    = SIZE_W'(kb);
        req_valid = rv;
        req_addr  = rv ? a : '0;
        if (rv) begin
            model(a, e);
            e.cyc = cyc_cnt;
            e.tag = tag;
            sb.push_back(e);
        end
        if (we) msize[slot] = kb;
    endtask

    task automatic wr(input int slot, input int unsigned kb);
        cycle(1'b1, slot, kb, 1'b0, '0, "");
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, input string tag);
        cycle(1'b0, 0, 0, 1'b1, a, tag);
    endtask

    task automatic idle();
        cycle(1'b0, 0, 0, 1'b0, '0, "");
    endtask

    // Monitor: samples after each rising edge and scores responses.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (rst_n && !done) begin
                if (rsp_valid) begin
                    n_checks++;
                    if (sb.size() == 0) begin
                        n_fail++;
                        $display("FAIL R8: response with nothing pending cs=%b miss=%b exp none",
                                 rsp_cs, rsp_miss);
                    end else begin
                        e = sb.pop_front();
                        if (rsp_cs !== e.cs || rsp_offset !== e.off || rsp_miss !== e.miss
                            || cyc_cnt != e.cyc + 1) begin
                            n_fail++;
                            $display("FAIL %s: cs=%b off=%h miss=%b cyc=%0d exp cs=%b off=%h miss=%b cyc=%0d",
                                     e.tag, rsp_cs, rsp_offset, rsp_miss, cyc_cnt,
                                     e.cs, e.off, e.miss, e.cyc + 1);
                        end
                    end
                end else begin
                    n_checks++;
                    if (rsp_cs !== 4'b0 || rsp_miss !== 1'b0 || rsp_offset !== '0
                        || (sb.size() != 0 && cyc_cnt >= sb[0].cyc + 1)) begin
                        n_fail++;
                        $display("FAIL R8: idle cs=%b miss=%b off=%h pending=%0d exp zeros, none due",
                                 rsp_cs, rsp_miss, rsp_offset, sb.size());
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) msize[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs idle after reset
        n_checks++;
        if (rsp_valid !== 1'b0 || rsp_cs !== 4'b0 || rsp_miss !== 1'b0 || rsp_offset !== '0) begin
            n_fail++;
            $display("FAIL R1: valid=%b cs=%b miss=%b off=%h exp all zero",
                     rsp_valid, rsp_cs, rsp_miss, rsp_offset);
        end
        rd(32'h0, "R1");                     // all sizes zero -> miss
        idle();

        // R5: whole 4 MB window in B1, others zero (R4)
        wr(2, 4096);
        rd(32'h0000_0000, "R5");
        rd(32'h0012_3456, "R5");
        rd(32'h003F_FFFF, "R5");
        rd(32'h0040_0000, "R7");             // first byte past the window
        idle();

        // R2/R3/R4: A1=1K, A2=2K, B1=0, B2=4K
        wr(0, 1); wr(1, 2); wr(2, 0); wr(3, 4);
        rd(32'h0000_0000, "R2");
        rd(32'h0000_03FF, "R3");
        rd(32'h0000_0400, "R6");
        idle();
        rd(32'h0000_0BFF, "R6");
        rd(32'h0000_0C00, "R4");             // B1 empty, B2 starts here
        rd(32'h0000_1BFF, "R3");
        rd(32'h0000_1C00, "R7");
        rd(32'hFFFF_FFFF, "R7");
        idle(); idle();

        // R9: write B1 and request in the same cycle -> old layout
        cycle(1'b1, 2, 1, 1'b1, 32'h0000_1C00, "R9");
        rd(32'h0000_1C00, "R9");             // new layout: B2 offset C00
        rd(32'h0000_0C00, "R9");             // B1 now populated
        rd(32'h0000_1FFF, "R10");
        cycle(1'b1, 3, 0, 1'b1, 32'h0000_1000, "R9");
        rd(32'h0000_1000, "R4");             // B2 removed -> miss
        idle(); idle(); idle();

        done = 1'b1;
        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R8: %0d responses missing, exp 0", sb.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule